// File: doc/BRIEF.md
# Clock Gear and Prescaler Controller

This block turns a fast source clock (fc) into a set of clock enables for the rest of a chip. A three-bit gear setting picks a system clock ratio of 1, 2, 4, 8 or 16 fc cycles and produces a one-cycle system enable pulse at that rate. A separate four-bit code picks a prescaler tick every 2^n fc cycles. A per-peripheral enable word gates the system enable into one clock enable per peripheral. All logic runs on fc with a synchronous active-high reset.

Software reaches the block through a small register port. A key register guards every other register: writes to the configuration and enable registers land only while the key holds 0xC1. A gear change does not cut the running system period short. The new ratio is adopted only when the current period completes. A read-only field reports the ratio in use, so software can tell when the switch has happened.

Register map (2-bit address, 32-bit data, unlisted bits read zero): address 0 is the key, bits [7:0]. Address 1 is the configuration, with the gear request in [2:0], the prescaler code in [7:4] and the gear in effect (read-only) in [10:8]. Address 2 is the peripheral enable word, bits [NPERIPH-1:0]. Address 3 reads zero.

Top module: `clkgear_ctrl`

## Requirements
- R1: After reset the key reads 0xC1, the gear request, gear in effect and prescaler code read 0, the enable word reads PEN_RST (default: only bit 0 set), sys_ce is high every cycle and presc_tick is high every cycle.
- R2: A write to address 1 or 2 changes that register only while the key register holds 0xC1. With any other key value the register keeps its contents. Address 0 accepts every write and reads back bits [7:0].
- R3: Gear codes 0 to 4 select system periods of 1, 2, 4, 8 and 16 fc cycles. A write carrying gear code 5, 6 or 7 leaves the gear request unchanged, while the prescaler field of the same write still applies.
- R4: A new gear request is adopted at the fc edge that ends the current system period. If the write lands at the edge that follows a sys_ce pulse of an old period of r cycles, then the gear-in-effect field [10:8] shows the new code exactly r edges later, which is never more than 16.
- R5: sys_ce is a one-cycle pulse once per system period. Across a gear change, every interval between pulses equals either the old or the new period, so no shortened period occurs.
- R6: Prescaler code n from 0 to 9 gives presc_tick once every 2^n fc cycles. A write with code 10 to 15 leaves the prescaler code unchanged.
- R7: periph_ce[i] equals sys_ce while enable bit i is 1 and stays 0 while it is 0.
- R8: Every address can be read at any time, including while writes are locked. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock fc |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sys_ce | output | 1 | System clock enable, one pulse per gear period |
| presc_tick | output | 1 | Prescaler tick, one pulse per 2^n fc cycles |
| periph_ce | output | NPERIPH | Per-peripheral gated clock enables |

## Verification
A divider counter that runs past its terminal value, or a gear adopted mid-period, shows up at sys_ce as a pulse interval that matches neither the old ratio nor the new one. It shows within one period of at most 16 cycles, and the gear-in-effect field switches on the wrong edge. A lock that leaks, or a reserved code that gets stored, is visible on the next readback, and for the gear also in the next pulse spacing. A wrong enable bit is caught at periph_ce on the next sys_ce pulse.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;

    localparam int GEAR_W        = 3;
    localparam int GEAR_MAX_CODE = 4;
    localparam int DIV_CW        = GEAR_MAX_CODE;
    localparam int PSEL_W        = 4;
    localparam int REG_AW        = 2;
    localparam int REG_DW        = 32;

    typedef enum logic [REG_AW-1:0] {
        ADDR_KEY  = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_PEN  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [GEAR_W-1:0] gear;
    } clk_cfg_t;

    function automatic logic gear_code_ok(logic [GEAR_W-1:0] code);
        return int'(code) <= GEAR_MAX_CODE;
    endfunction

    // terminal count of the gear divider: ratio minus one
    function automatic logic [DIV_CW-1:0] gear_last(logic [GEAR_W-1:0] code);
        logic [DIV_CW-1:0] m;
        m = '0;
        for (int i = 0; i < DIV_CW; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cg_regfile.sv
module cg_regfile
    import clkgear_pkg::*;
#(
    parameter int                  NPERIPH    = 8,
    parameter logic [NPERIPH-1:0]  PEN_RST    = {{(NPERIPH-1){1'b0}}, 1'b1},
    parameter int                  KEY_W      = 8,
    parameter logic [KEY_W-1:0]    UNLOCK_KEY = 8'hC1,
    parameter int                  PSEL_MAX   = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [REG_DW-1:0]    wdata,
    input  logic [GEAR_W-1:0]    gear_eff,
    output logic [REG_DW-1:0]    rdata,
    output clk_cfg_t             cfg,
    output logic [NPERIPH-1:0]   pen
);

    reg_addr_e          a;
    logic [KEY_W-1:0]   key_q;
    clk_cfg_t           cfg_q;
    logic [NPERIPH-1:0] pen_q;
    logic               unlocked;
    logic               wr_key, wr_cfg, wr_pen;
    logic [GEAR_W-1:0]  wd_gear;
    logic [PSEL_W-1:0]  wd_psel;
    logic               unused_wd;

    assign a         = reg_addr_e'(addr);
    assign unlocked  = (key_q == UNLOCK_KEY);
    assign wr_key    = we && (a == ADDR_KEY);
    assign wr_cfg    = we && (a == ADDR_CFG) && unlocked;
    assign wr_pen    = we && (a == ADDR_PEN) && unlocked;
    assign wd_gear   = wdata[GEAR_W-1:0];
    assign wd_psel   = wdata[PSEL_W+3:4];
    assign unused_wd = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= UNLOCK_KEY;
            cfg_q <= '0;
            pen_q <= PEN_RST;
        end else begin
            if (wr_key) key_q <= wdata[KEY_W-1:0];
            if (wr_cfg) begin
                if (gear_code_ok(wd_gear))       cfg_q.gear <= wd_gear;
                if (int'(wd_psel) <= PSEL_MAX)   cfg_q.psel <= wd_psel;
            end
            if (wr_pen) pen_q <= wdata[NPERIPH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (a)
            ADDR_KEY: rdata[KEY_W-1:0] = key_q;
            ADDR_CFG: begin
                rdata[GEAR_W-1:0]   = cfg_q.gear;
                rdata[PSEL_W+3:4]   = cfg_q.psel;
                rdata[GEAR_W+7:8]   = gear_eff;
            end
            ADDR_PEN: rdata[NPERIPH-1:0] = pen_q;
            default:  rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
    assign pen = pen_q;

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (we && (a != ADDR_KEY) && (key_q != UNLOCK_KEY)) |=> ($stable(cfg_q) && $stable(pen_q)));

    // R3
    gear_legal_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q.gear) <= GEAR_MAX_CODE);

    // R6
    psel_legal_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cfg_q.psel) <= PSEL_MAX);

endmodule

// File: rtl/cg_gear_div.sv
module cg_gear_div
    import clkgear_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GEAR_W-1:0] gear_req,
    output logic              sys_ce,
    output logic [GEAR_W-1:0] gear_eff
);

    logic [DIV_CW-1:0] cnt;
    logic [GEAR_W-1:0] eff_q;
    logic [DIV_CW-1:0] last;
    logic              term;

    assign last = gear_last(eff_q);
    assign term = (cnt == last);

    // the ratio is only swapped when the running period ends
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            eff_q <= '0;
        end else if (term) begin
            cnt   <= '0;
            eff_q <= gear_req;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    assign sys_ce   = term;
    assign gear_eff = eff_q;

    // R4
    eff_switch_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(eff_q) |-> $past(sys_ce));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R5
    pulse_restart_chk: assert property (@(posedge clk) disable iff (rst)
        sys_ce |=> (cnt == '0));

endmodule

// File: rtl/cg_prescaler.sv
module cg_prescaler
    import clkgear_pkg::*;
#(
    parameter int PSEL_MAX = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);

    localparam int PCW = (PSEL_MAX < 1) ? 1 : PSEL_MAX;

    logic [PCW-1:0] cnt;
    logic [PCW-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PCW; i++) begin
            if (i < int'(psel)) mask[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign tick = ((cnt & mask) == mask);

    // R6
    tick_space_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (psel != '0)) |=> (!tick || (psel != $past(psel))));

endmodule

// File: rtl/clkgear_ctrl.sv
module clkgear_ctrl
    import clkgear_pkg::*;
#(
    parameter int                 NPERIPH    = 8,
    parameter logic [NPERIPH-1:0] PEN_RST    = {{(NPERIPH-1){1'b0}}, 1'b1},
    parameter int                 KEY_W      = 8,
    parameter logic [KEY_W-1:0]   UNLOCK_KEY = 8'hC1,
    parameter int                 PSEL_MAX   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               sys_ce,
    output logic               presc_tick,
    output logic [NPERIPH-1:0] periph_ce
);

    clk_cfg_t           cfg;
    logic [NPERIPH-1:0] pen;
    logic [GEAR_W-1:0]  gear_eff;

    cg_regfile #(
        .NPERIPH    (NPERIPH),
        .PEN_RST    (PEN_RST),
        .KEY_W      (KEY_W),
        .UNLOCK_KEY (UNLOCK_KEY),
        .PSEL_MAX   (PSEL_MAX)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .gear_eff (gear_eff),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .pen      (pen)
    );

    cg_gear_div u_gear (
        .clk      (clk),
        .rst      (rst),
        .gear_req (cfg.gear),
        .sys_ce   (sys_ce),
        .gear_eff (gear_eff)
    );

    cg_prescaler #(
        .PSEL_MAX (PSEL_MAX)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .psel (cfg.psel),
        .tick (presc_tick)
    );

    for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
        assign periph_ce[i] = pen[i] & sys_ce;
    end

    // R7
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (|periph_ce) |-> sys_ce);

endmodule

// File: tb/clkgear_ctrl_test.sv
module clkgear_ctrl_test;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          sys_ce, presc_tick;
    logic [NP-1:0] periph_ce;

    clkgear_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .sys_ce(sys_ce), .presc_tick(presc_tick), .periph_ce(periph_ce)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0]    m_key  = 8'hC1;
    logic [2:0]    m_gear = 3'd0, m_gear_old = 3'd0;
    logic [3:0]    m_psel = 4'd0;
    logic [NP-1:0] m_pen  = 8'h01;
    bit            mon_on = 0;
    int            cyc = 0, last_pulse = -1, iv_bad = 0, gate_bad = 0;

    function automatic int ratio(logic [2:0] g);
        return 1 << g;
    endfunction
    function automatic bit gear_ok(logic [2:0] g);
        return g <= 3'd4;
    endfunction
    function automatic bit psel_ok(logic [3:0] p);
        return p <= 4'd9;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sync=1: launch the write at the negedge where a sys_ce pulse is visible
    task automatic wr(logic [1:0] a, logic [31:0] d, bit sync);
        if (sync) begin
            do @(negedge clk); while (!sys_ce);
        end else begin
            @(negedge clk);
        end
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 we = 1'b0;
        case (a)
            2'd0: m_key = d[7:0];
            2'd1: if (m_key == 8'hC1) begin
                      if (gear_ok(d[2:0])) begin m_gear_old = m_gear; m_gear = d[2:0]; end
                      if (psel_ok(d[7:4])) m_psel = d[7:4];
                  end
            2'd2: if (m_key == 8'hC1) m_pen = d[NP-1:0];
            default: ;
        endcase
    endtask

    task automatic rd(logic [1:0] a, output int v);
        addr = a;
        #1 v = int'(rdata);
    endtask

    // called right after a CFG write; counts edges until the gear in effect matches
    task automatic settle(output int n);
        n = 0;
        while (int'(rdata[10:8]) != int'(m_gear) && n < 40) begin
            @(posedge clk);
            #1 n++;
        end
        m_gear_old = m_gear;
    endtask

    task automatic meas_ce(output int c);
        do @(negedge clk); while (!sys_ce);
        c = 0;
        do begin @(negedge clk); c++; end while (!sys_ce);
    endtask

    task automatic meas_tick(output int c);
        do @(negedge clk); while (!presc_tick);
        c = 0;
        do begin @(negedge clk); c++; end while (!presc_tick);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (periph_ce !== (m_pen & {NP{sys_ce}})) gate_bad++;
            if (sys_ce) begin
                if (last_pulse >= 0) begin
                    if ((cyc - last_pulse) != ratio(m_gear) &&
                        (cyc - last_pulse) != ratio(m_gear_old)) iv_bad++;
                end
                last_pulse = cyc;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, n, c;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1;

        // R1 reset state
        rd(2'd0, v); chk("R1 key", v, 32'hC1);
        rd(2'd1, v); chk("R1 cfg", v, 0);
        rd(2'd2, v); chk("R1 pen", v, 1);
        rd(2'd3, v); chk("R8 addr3", v, 0);
        @(negedge clk);
        chk("R1 sys_ce", int'(sys_ce), 1);
        chk("R1 presc_tick", int'(presc_tick), 1);

        // R4 from fc to /16, then deferred switch back
        wr(2'd1, 32'h0000_0004, 1'b1); settle(n); chk("R4 from fc", n, 1);
        meas_ce(c); chk("R3 gear /16", c, 16);
        wr(2'd1, 32'h0000_0001, 1'b1); settle(n); chk("R4 deferred /16", n, 16);
        meas_ce(c); chk("R3 gear /2", c, 2);
        wr(2'd1, 32'h0000_0003, 1'b1); settle(n); chk("R4 deferred /2", n, 2);
        meas_ce(c); chk("R5 gear /8", c, 8);

        // R3 reserved gear code, prescaler field still applies
        wr(2'd1, 32'h0000_0036, 1'b0);
        rd(2'd1, v); chk("R3 reserved gear kept", v & 7, 3);
        chk("R3 psel applied", (v >> 4) & 15, 3);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R3 eff kept", (v >> 8) & 7, 3);

        // R6 prescaler codes
        foreach (c_list[i]) begin
            wr(2'd1, {24'd0, c_list[i], 4'd3}, 1'b0);
            meas_tick(c); chk($sformatf("R6 psel %0d", c_list[i]), c, 1 << c_list[i]);
        end
        wr(2'd1, 32'h0000_00C3, 1'b0);
        rd(2'd1, v); chk("R6 reserved psel kept", (v >> 4) & 15, 9);
        meas_tick(c); chk("R6 /512 after reserved", c, 512);

        // R2 lock, R8 reads while locked
        wr(2'd0, 32'h0000_005A, 1'b0);
        rd(2'd0, v); chk("R8 key read locked", v, 32'h5A);
        wr(2'd1, 32'h0000_0020, 1'b0);
        wr(2'd2, 32'h0000_00F0, 1'b0);
        rd(2'd1, v); chk("R2 cfg locked", v & 32'hFF, 32'h93);
        rd(2'd2, v); chk("R2 pen locked", v, 1);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R2 eff locked", (v >> 8) & 7, 3);
        wr(2'd0, 32'h0000_00C1, 1'b0);
        wr(2'd2, 32'h0000_00F0, 1'b0);
        rd(2'd2, v); chk("R2 pen unlocked", v, 32'hF0);

        // R7 gating: bit 7 pulses at the gear rate, bit 0 silent
        n = 0; v = 0;
        @(negedge clk);
        repeat (64) begin
            @(negedge clk);
            if (periph_ce[7]) n++;
            if (periph_ce[0]) v++;
        end
        chk("R7 enabled bit pulses", n, 8);
        chk("R7 disabled bit quiet", v, 0);

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                logic [2:0] g; logic [3:0] p; logic [2:0] old; int expn;
                g = 3'($urandom); p = 4'($urandom); old = m_gear;
                wr(2'd1, {24'd0, p, 1'b0, g}, 1'b1);
                expn = (gear_ok(g) && g != old) ? ratio(old) : 0;
                settle(n); chk("R4 random switch", n, expn);
                rd(2'd1, v);
                chk("R3 random gear", v & 7, int'(m_gear));
                chk("R6 random psel", (v >> 4) & 15, int'(m_psel));
            end else if (op == 1) begin
                logic [7:0] d;
                d = 8'($urandom);
                wr(2'd2, {24'd0, d}, 1'b0);
                rd(2'd2, v); chk("R2 random pen", v, int'(m_pen));
            end else begin
                logic [7:0] key, d;
                key = ($urandom % 2) ? 8'hC1 : 8'($urandom);
                d = 8'($urandom);
                wr(2'd0, {24'd0, key}, 1'b0);
                rd(2'd0, v); chk("R8 random key", v, int'(key));
                wr(2'd2, {24'd0, d}, 1'b0);
                rd(2'd2, v); chk("R2 random locked pen", v, int'(m_pen));
                wr(2'd0, 32'h0000_00C1, 1'b0);
            end
        end

        @(negedge clk);
        chk("R5 interval monitor", iv_bad, 0);
        chk("R7 gating monitor", gate_bad, 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int c_list[4] = '{0, 1, 4, 9};

endmodule